// File: doc/BRIEF.md
# Configurable SPI Serial Engine

This block is a single SPI shift engine whose behaviour is set by a 16-bit control word. The word selects whether the engine generates the serial clock (master) or follows an external one (slave). It also sets the clock idle level, the clock edge on which outgoing data changes, and, in master role only, whether incoming data is captured in the middle or at the end of each bit. Further bits choose 8-bit or 16-bit words, release the clock and data-out pins to general I/O, make the engine honour a slave-select input, and set a two-stage divider for the generated clock.

Software writes the control word, places a word on `tx_word` and pulses `start`. In master role the engine produces the clock and finishes on its own. In slave role, `start` arms the engine and the external clock moves the bits. `busy` is high while a word is in flight. `done` pulses for one cycle in the same cycle that `rx_word` takes the received word. In slave role the clock, data-in and select pins pass through a two-stage synchronizer, so the system clock must run well above the serial clock.

Top module: `spi_engine`

## Requirements
- R1: The control word resets to zero and reads back on `ctl_rdata`. Its fields are: bit 0 master role, bit 1 clock idles high, bit 2 output changes on the active-to-idle edge, bit 3 end-of-bit input sampling, bit 4 16-bit words, bit 5 release SCK, bit 6 release SDO, bit 7 use slave-select, bits 9:8 primary divider code, bits 12:10 secondary divider code. Bits 15:13 always read 0.
- R2: The end-of-bit sampling bit reads 0 whenever bit 0 is 0. A write that sets it together with bit 0 = 0 leaves it 0, and a write that clears bit 0 also clears it.
- R3: In master role `sck_o` sits at the idle level of bit 1 while idle. It toggles exactly twice per data bit, and each level lasts D system clocks, where D is the divide ratio.
- R4: The primary code maps 3, 2, 1, 0 to 1, 4, 16, 64 and the secondary code maps 7 down to 0 to 1 through 8, with D equal to their product. When both are 1, the secondary becomes 2 (D = 2).
- R5: With bit 2 set, the first data bit (MSB first) is on `sdo_o` from the start, and the next bit appears at each active-to-idle clock edge.
- R6: With bit 2 clear, `sdo_o` keeps the first bit through the first idle-to-active edge, and the next bit appears at each later idle-to-active edge.
- R7: In master role the input is captured at the clock edge in the middle of each bit when bit 3 is 0, and at the edge that ends the bit when bit 3 is 1. With bit 2 clear and end-of-bit sampling, one extra idle half-period follows the last clock edge.
- R8: With bit 4 clear a word is 8 bits: `tx_word[7:0]` is sent and `rx_word[15:8]` reads 0. With bit 4 set all 16 bits are used.
- R9: `start` is accepted only when `busy` is low. `done` is a single-cycle pulse, issued as `busy` falls, with `rx_word` valid in that cycle.
- R10: `sck_oe` is high only in master role with bit 5 clear. `sdo_oe` is low when bit 6 is set. In slave role with bit 7 set, `sdo_oe` is also low while `ss_n_i` is high.
- R11: In slave role an armed engine samples on the external clock edge opposite to the one on which it changes data (R5/R6), and raises `done` after the last bit of the word.
- R12: In slave role with bit 7 set, `ss_n_i` going high aborts the word: `busy` drops and no `done` follows. With bit 7 clear, `ss_n_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write value |
| ctl_rdata | output | 16 | Control word as held |
| start | input | 1 | Begin (master) or arm (slave) one word |
| tx_word | input | WORD_W | Word to send |
| rx_word | output | WORD_W | Last word received |
| busy | output | 1 | Word in flight |
| done | output | 1 | One-cycle pulse at word end |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Drive enable for the clock pin |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the data-out pin |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The bench runs a clock-by-clock model of master role that tracks the divider, edge count, shift count and captured bits. It feeds a serial input that changes every half-period, so capturing at the wrong edge corrupts `rx_word`. A design that swapped middle and end sampling, or missed the extra tail half-period with the late edge clear, would return a shifted word. Shifting on the first leading edge would put bit 6 on `sdo_o` one half-period early. Skipping the forced divide-by-2 would toggle `sck_o` every cycle. Slave runs cover both edge settings and both widths, a select-line abort that would otherwise leave `busy` stuck or emit a stray `done`, and a select line that must be ignored when its enable is clear.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int CFG_W = 16;
  localparam int DIV_W = 10;

  // Control word layout, LSB last
  typedef struct packed {
    logic [2:0] rsv;
    logic [2:0] sec_code;
    logic [1:0] pri_code;
    logic       ss_use;
    logic       sdo_rel;
    logic       sck_rel;
    logic       wide;
    logic       samp_end;
    logic       edge_late;
    logic       idle_hi;
    logic       master;
  } spi_cfg_t;

  // Half-period length in system clocks for the generated clock
  function automatic logic [DIV_W-1:0] half_period(input logic [1:0] pri,
                                                   input logic [2:0] sec);
    logic [DIV_W-1:0] p;
    logic [DIV_W-1:0] s;
    p = DIV_W'(1) << {~pri, 1'b0};
    s = DIV_W'(8) - {{(DIV_W-3){1'b0}}, sec};
    if (p == DIV_W'(1) && s == DIV_W'(1)) s = DIV_W'(2);
    return p * s;
  endfunction

endpackage

// File: rtl/spi_ctl_reg.sv
module spi_ctl_reg
  import spi_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output spi_cfg_t         cfg
);

  spi_cfg_t w;
  assign w = spi_cfg_t'(wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (we) begin
      cfg          <= w;
      cfg.rsv      <= '0;
      cfg.samp_end <= w.samp_end & w.master;
    end
  end

  // R2
  samp_master_chk: assert property (@(posedge clk) disable iff (rst)
    cfg.samp_end |-> cfg.master);

endmodule

// File: rtl/spi_divider.sv
module spi_divider #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] limit,
  output logic          tick
);

  logic [DW-1:0] cnt;

  assign tick = run && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/spi_core.sv
module spi_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         c_master,
  input  logic         c_idle_hi,
  input  logic         c_edge_late,
  input  logic         c_samp_end,
  input  logic         c_wide,
  input  logic         c_ss_use,
  input  logic         start,
  input  logic [W-1:0] tx_word,
  input  logic         tick,
  input  logic         sdi_m,
  input  logic         sdi_s,
  input  logic         sck_s,
  input  logic         ss_n_s,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_word,
  output logic         sck_q,
  output logic         sdo_bit
);

  localparam int HALF = W / 2;
  localparam int KW   = $clog2(2 * W + 2);

  logic [KW-1:0] k, k_nx, nbits, two_n, last_k;
  logic [W-1:0]  tx_sr, rx_sr, rx_nx, rx_fin;
  logic          sck_d, first_seen;
  logic          m_samp, m_shift, m_tog, m_last, odd, late3;
  logic          edge_s, lead, trail, abort, s_samp, s_shift, s_last;
  logic          samp_ev, shift_ev, fin, load, in_bit;

  assign nbits  = c_wide ? KW'(W) : KW'(HALF);
  assign two_n  = nbits << 1;
  assign last_k = c_edge_late ? two_n : two_n + 1'b1;
  assign k_nx   = k + 1'b1;

  // Master: what happens at the next clock boundary
  always_comb begin
    odd   = k_nx[0];
    late3 = k_nx >= KW'(3);
    if (c_edge_late) begin
      m_samp  = c_samp_end ? !odd : odd;
      m_shift = !odd && (k_nx < two_n);
    end else begin
      m_samp  = c_samp_end ? (odd && late3) : !odd;
      m_shift = odd && late3 && (k_nx < last_k);
    end
    m_tog  = k_nx <= two_n;
    m_last = k_nx == last_k;
  end

  // Slave: edges of the synchronized external clock
  assign edge_s  = sck_s ^ sck_d;
  assign lead    = edge_s && (sck_s != c_idle_hi);
  assign trail   = edge_s && (sck_s == c_idle_hi);
  assign abort   = c_ss_use && ss_n_s;
  assign s_samp  = c_edge_late ? lead : trail;
  assign s_shift = c_edge_late ? trail : (lead && first_seen);
  assign s_last  = s_samp && (k_nx == nbits);

  assign samp_ev  = busy && (c_master ? (tick && m_samp)  : (!abort && s_samp));
  assign shift_ev = busy && (c_master ? (tick && m_shift) : (!abort && s_shift));
  assign fin      = busy && (c_master ? (tick && m_last)  : (!abort && s_last));
  assign load     = start && !busy && (c_master || !abort);

  assign in_bit = c_master ? sdi_m : sdi_s;
  assign rx_nx  = {rx_sr[W-2:0], in_bit};
  assign rx_fin = samp_ev ? rx_nx : rx_sr;

  assign sdo_bit = tx_sr[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      k          <= '0;
      tx_sr      <= '0;
      rx_sr      <= '0;
      rx_word    <= '0;
      sck_q      <= 1'b0;
      sck_d      <= 1'b0;
      first_seen <= 1'b0;
    end else begin
      done  <= 1'b0;
      sck_d <= sck_s;
      if (load) begin
        busy       <= 1'b1;
        k          <= '0;
        first_seen <= 1'b0;
        sck_q      <= c_idle_hi;
        tx_sr      <= c_wide ? tx_word : {tx_word[HALF-1:0], {HALF{1'b0}}};
      end else if (busy) begin
        if (!c_master && abort) begin
          busy       <= 1'b0;
          k          <= '0;
          first_seen <= 1'b0;
        end else begin
          if (samp_ev)  rx_sr <= rx_nx;
          if (shift_ev) tx_sr <= {tx_sr[W-2:0], 1'b0};
          if (c_master) begin
            if (tick) begin
              k <= k_nx;
              if (m_tog) sck_q <= ~sck_q;
            end
          end else begin
            if (s_samp) k <= k_nx;
            if (lead)   first_seen <= 1'b1;
          end
          if (fin) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_word <= c_wide ? rx_fin : {{HALF{1'b0}}, rx_fin[HALF-1:0]};
          end
        end
      end
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R3
  edge_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && c_master) |-> (k < last_k));
  // R12
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !c_master && c_ss_use && ss_n_s) |=> (!busy && !done));

endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_eng_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [CFG_W-1:0]  ctl_wdata,
  output logic [CFG_W-1:0]  ctl_rdata,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              busy,
  output logic              done,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe,
  input  logic              ss_n_i
);

  spi_cfg_t         cfg;
  logic [2:0]       pins_s;
  logic             sck_s, sdi_s, ss_n_s, tick, sck_q;
  logic [DIV_W-1:0] limit;

  spi_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata), .cfg(cfg)
  );

  spi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({sck_i, sdi_i, ss_n_i}), .q(pins_s)
  );
  assign {sck_s, sdi_s, ss_n_s} = pins_s;

  assign limit = half_period(cfg.pri_code, cfg.sec_code);

  spi_divider #(.DW(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(busy && cfg.master), .limit(limit), .tick(tick)
  );

  spi_core #(.W(WORD_W)) u_core (
    .clk(clk), .rst(rst),
    .c_master(cfg.master), .c_idle_hi(cfg.idle_hi), .c_edge_late(cfg.edge_late),
    .c_samp_end(cfg.samp_end), .c_wide(cfg.wide), .c_ss_use(cfg.ss_use),
    .start(start), .tx_word(tx_word), .tick(tick),
    .sdi_m(sdi_i), .sdi_s(sdi_s), .sck_s(sck_s), .ss_n_s(ss_n_s),
    .busy(busy), .done(done), .rx_word(rx_word), .sck_q(sck_q), .sdo_bit(sdo_o)
  );

  assign ctl_rdata = cfg;
  assign sck_o     = (busy && cfg.master) ? sck_q : cfg.idle_hi;
  assign sck_oe    = cfg.master && !cfg.sck_rel;
  assign sdo_oe    = !cfg.sdo_rel && (cfg.master || !cfg.ss_use || !ss_n_s);

  // R1
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[15:13] == 3'b000);
  // R2
  samp_read_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_rdata[0] |-> !ctl_rdata[3]);
  // R10
  sck_oe_chk: assert property (@(posedge clk) disable iff (rst)
    sck_oe |-> ctl_rdata[0]);

endmodule

// File: tb/spi_engine_bench.sv
module spi_engine_bench;

  localparam int H = 8;
  localparam logic [63:0] PTN = 64'h9E37_79B9_7F4A_7C15;

  logic        clk = 1'b0, rst = 1'b1, ctl_we = 1'b0, start = 1'b0;
  logic [15:0] ctl_wdata = '0, tx_word = '0;
  logic        sck_i = 1'b0, sdi = 1'b0, ss_n = 1'b0;
  logic [15:0] ctl_rdata, rx_word;
  logic        busy, done, sck_o, sck_oe, sdo_o, sdo_oe;

  int checks = 0, errors = 0, cyc = 0, done_cnt = 0;
  bit ended = 0, model_en = 0;
  logic [15:0] cur = '0, last_rx = '0;

  // behavioural model state (master role)
  bit m_busy = 0, m_done = 0, m_sck = 0;
  int m_cnt = 0, m_k = 0, m_shift = 0;
  logic [15:0] m_rx = '0, m_rxw = '0, m_tx = '0;

  spi_engine u_spi_engine (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .start(start), .tx_word(tx_word), .rx_word(rx_word), .busy(busy), .done(done),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdi_i(sdi), .sdo_o(sdo_o),
    .sdo_oe(sdo_oe), .ss_n_i(ss_n)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic int dv(input logic [1:0] p, input logic [2:0] s);
    int a, b;
    case (p)
      2'd3: a = 1;
      2'd2: a = 4;
      2'd1: a = 16;
      default: a = 64;
    endcase
    b = 8 - int'(s);
    if (a == 1 && b == 1) b = 2;
    return a * b;
  endfunction

  function automatic logic [15:0] mk(input bit ms, ckp, cke, smp, wd, sckr, sdor, ssu,
                                     input logic [1:0] pr, input logic [2:0] sc);
    return {3'b000, sc, pr, ssu, sdor, sckr, wd, smp, cke, ckp, ms};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  always @(negedge clk) if (!rst && done) begin
    done_cnt++;
    last_rx = rx_word;
  end

  // Reference model: advances on each rising edge
  always @(posedge clk) begin
    int n, d, lk;
    bit smp, sh, odd;
    if (rst || !model_en) begin
      m_busy = 0; m_done = 0; m_k = 0;
    end else begin
      n  = cur[4] ? 16 : 8;
      d  = dv(cur[9:8], cur[12:10]);
      lk = cur[2] ? 2 * n : 2 * n + 1;
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_cnt = 0; m_k = 0; m_sck = cur[1]; m_shift = 0; m_rx = '0;
          m_tx = cur[4] ? tx_word : {8'h00, tx_word[7:0]};
        end
      end else begin
        m_cnt++;
        if (m_cnt == d) begin
          m_cnt = 0;
          m_k++;
          odd = (m_k % 2) == 1;
          if (m_k <= 2 * n) m_sck = !m_sck;
          if (cur[2]) begin
            smp = cur[3] ? !odd : odd;
            sh  = !odd && m_k < 2 * n;
          end else begin
            smp = cur[3] ? (odd && m_k >= 3) : !odd;
            sh  = odd && m_k >= 3 && m_k < lk;
          end
          if (smp) m_rx = {m_rx[14:0], PTN[m_k-1]};
          if (sh) m_shift++;
          if (m_k == lk) begin
            m_busy = 0; m_done = 1;
            m_rxw = (n == 16) ? m_rx : {8'h00, m_rx[7:0]};
          end
        end
      end
    end
  end

  // Clock-by-clock comparison and serial input drive in master role
  always @(negedge clk) if (!rst && model_en) begin
    int n;
    n = cur[4] ? 16 : 8;
    chk(busy === m_busy, "R9 busy", busy, m_busy);
    chk(done === m_done, "R9 done", done, m_done);
    chk(sck_o === (m_busy ? m_sck : cur[1]), "R3 R4 sck", sck_o, m_busy ? m_sck : cur[1]);
    chk(sck_oe === !cur[5], "R10 sck_oe", sck_oe, !cur[5]);
    chk(sdo_oe === !cur[6], "R10 sdo_oe", sdo_oe, !cur[6]);
    if (m_busy)
      chk(sdo_o === m_tx[n-1-m_shift], cur[2] ? "R5 sdo" : "R6 sdo", sdo_o, m_tx[n-1-m_shift]);
    if (m_done)
      chk(rx_word === m_rxw, "R7 R8 rx", rx_word, m_rxw);
    sdi = PTN[m_k];
  end

  task automatic wr_cfg(input logic [15:0] v);
    model_en = 0;
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
    cur = v & 16'h1FFF;
    if (!v[0]) cur[3] = 1'b0;
    model_en = v[0];
  endtask

  task automatic run_master(input logic [15:0] v, input logic [15:0] txw, input bit poke);
    int guard = 0;
    wr_cfg(v);
    @(negedge clk); start = 1'b1; tx_word = txw;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1; tx_word = ~txw;   // R9: ignored while busy
      @(negedge clk); start = 1'b0;
    end
    while (m_busy && guard < 2000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic slave_xfer(input bit cke, ckp, wd, ssu, input logic [15:0] txw, rxw);
    int n, base;
    n = wd ? 16 : 8;
    wr_cfg(mk(0, ckp, cke, 0, wd, 0, 0, ssu, 2'd0, 3'd0));
    sck_i = ckp;
    repeat (6) @(negedge clk);
    chk(sck_oe === 1'b0, "R10 slave sck_oe", sck_oe, 0);
    base = done_cnt;
    @(negedge clk); start = 1'b1; tx_word = txw;
    @(negedge clk); start = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      if (cke) begin
        sdi = rxw[i];
        repeat (H) @(negedge clk);
        chk(sdo_o === txw[i], "R11 R5 slave sdo", sdo_o, txw[i]);
        sck_i = !ckp;
        repeat (H) @(negedge clk);
        sck_i = ckp;
        repeat (H) @(negedge clk);
      end else begin
        sck_i = !ckp; sdi = rxw[i];
        repeat (H) @(negedge clk);
        chk(sdo_o === txw[i], "R11 R6 slave sdo", sdo_o, txw[i]);
        sck_i = ckp;
        repeat (H) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    chk(done_cnt == base + 1, "R11 slave done", done_cnt, base + 1);
    chk(last_rx === (wd ? rxw : {8'h00, rxw[7:0]}), "R8 R11 slave rx", last_rx,
        wd ? rxw : {8'h00, rxw[7:0]});
  endtask

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(ctl_rdata === 16'h0000, "R1 reset ctl", ctl_rdata, 0);
    chk(busy === 1'b0, "R9 reset busy", busy, 0);
    chk(done === 1'b0, "R9 reset done", done, 0);
    chk(sck_oe === 1'b0, "R10 reset sck_oe", sck_oe, 0);
    chk(sdo_oe === 1'b1, "R10 reset sdo_oe", sdo_oe, 1);

    // control word readback
    wr_cfg(16'hFFFF);
    chk(ctl_rdata === 16'h1FFF, "R1 top bits zero", ctl_rdata, 16'h1FFF);
    wr_cfg(16'h0008);
    chk(ctl_rdata === 16'h0000, "R2 sample bit ignored in slave", ctl_rdata, 0);
    wr_cfg(16'h0009);
    chk(ctl_rdata === 16'h0009, "R2 sample bit kept in master", ctl_rdata, 16'h0009);
    wr_cfg(16'h0008);
    chk(ctl_rdata === 16'h0000, "R2 sample bit cleared leaving master", ctl_rdata, 0);

    // master role, clock-by-clock model
    run_master(mk(1, 0, 1, 0, 0, 0, 0, 0, 2'd3, 3'd7), 16'h00A5, 0); // R4 forced /2
    run_master(mk(1, 1, 0, 0, 0, 0, 0, 0, 2'd3, 3'd6), 16'h003C, 0); // R6
    run_master(mk(1, 0, 0, 1, 1, 0, 0, 0, 2'd3, 3'd5), 16'hBEEF, 0); // R7 end, tail
    run_master(mk(1, 1, 1, 1, 1, 1, 0, 0, 2'd2, 3'd6), 16'h1234, 1); // R9 R10 sck release
    run_master(mk(1, 0, 1, 1, 0, 0, 1, 0, 2'd3, 3'd4), 16'h0081, 0); // R10 sdo release
    chk(done_cnt == 5, "R9 one done per master word", done_cnt, 5);

    // slave role
    ss_n = 1'b1;
    slave_xfer(1, 0, 0, 0, 16'h00C3, 16'h005A);  // R12: select ignored when unused
    ss_n = 1'b0;
    slave_xfer(0, 1, 1, 1, 16'hA1B2, 16'h6D4E);
    slave_xfer(1, 1, 1, 0, 16'h0F0F, 16'hF00D);
    slave_xfer(0, 0, 0, 0, 16'h0096, 16'h0071);

    // R12 abort by select
    wr_cfg(mk(0, 0, 1, 0, 0, 0, 0, 1, 2'd0, 3'd0));
    sck_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(sdo_oe === 1'b1, "R10 selected slave drives sdo", sdo_oe, 1);
    base = done_cnt;
    @(negedge clk); start = 1'b1; tx_word = 16'h00FF;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      repeat (H) @(negedge clk); sck_i = 1'b1;
      repeat (H) @(negedge clk); sck_i = 1'b0;
    end
    repeat (H) @(negedge clk);
    chk(busy === 1'b1, "R12 busy before abort", busy, 1);
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(busy === 1'b0, "R12 abort drops busy", busy, 0);
    chk(sdo_oe === 1'b0, "R12 sdo released when deselected", sdo_oe, 0);
    chk(done_cnt == base, "R12 no done on abort", done_cnt, base);
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(sdo_oe === 1'b1, "R12 sdo driven when reselected", sdo_oe, 1);

    finish_run();
  end

endmodule